// File: doc/BRIEF.md
# Horizontal Blanking Pulse Generator

This block produces the per-line horizontal blanking signal of an image sensor timing path. A pixel counter restarts on every line-start strobe, and up to six programmable toggle positions each invert the blanking level when the counter reaches them. The first pair of positions gives the ordinary blanking interval. The other four let one line carry additional pulse groups inside that interval.

A direction setting can switch the block to an externally supplied blanking input instead. That input is synchronised to the pixel clock and normalised to active-high using a polarity setting. In either mode, the incoming H1 horizontal clock is forced to a selectable level while blanking is active, and passes unchanged otherwise.

All settings are captured at the line-start strobe, so one line never mixes old and new settings.

Top module: `hblk_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first line-start strobe, `hblk_out` is 0 whatever the toggle positions are set to. During reset `h1_out` is also 0.
- R2: In internal mode (`cfg_ext_sel`=0), `hblk_out` is 0 in the cycle after the line-start edge. Pixel index 0 is that cycle. A valid toggle position p inverts `hblk_out` from pixel index p+1 onward. Position i occupies bits [i*CNT_W +: CNT_W] of `tog_pos`.
- R3: A toggle position equal to 0, or greater than the captured line length, never changes `hblk_out`.
- R4: Every valid position that matches counts as one inversion. Two positions holding the same value therefore cancel, and `hblk_out` is the parity of the matches passed so far.
- R5: After pixel index equal to the line length, `hblk_out` holds its level until the next line-start strobe.
- R6: When `cfg_ext_sel`=1, `hblk_out` follows `ext_hblk` through a two-flop synchroniser and the output register. A level sampled at edge n appears after edge n+2. In this mode the toggle positions have no effect.
- R7: The external polarity is set by `cfg_ext_pol`: 0 means active low (`hblk_out` = not `ext_hblk`) and 1 means active high (`hblk_out` = `ext_hblk`).
- R8: `h1_out` is registered. After each edge it equals `cfg_mask_lvl` when `hblk_out` is 1 (0 holds H1 low, 1 holds H1 high). Otherwise it equals `h1_in` as sampled at that edge.
- R9: `line_len`, `tog_pos`, `cfg_ext_sel`, `cfg_ext_pol` and `cfg_mask_lvl` are sampled only on the line-start edge. Changes in the middle of a line have no effect until the next line start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe that begins a line |
| line_len | input | CNT_W | Last pixel index of the line |
| tog_pos | input | NUM_TOG*CNT_W | Packed toggle positions; entry i at [i*CNT_W +: CNT_W] |
| cfg_ext_sel | input | 1 | 1 selects the external blanking input |
| cfg_ext_pol | input | 1 | External active level: 0 low, 1 high |
| cfg_mask_lvl | input | 1 | Level forced on H1 during blanking |
| ext_hblk | input | 1 | Asynchronous external blanking input |
| h1_in | input | 1 | Incoming H1 clock level |
| hblk_out | output | 1 | Active-high blanking, registered |
| h1_out | output | 1 | Masked H1, registered |

## Verification
Two events can fall in the same cycle: a line-start strobe, and a toggle match left over from the previous line's counter. A configuration change can also coincide with that same strobe. The bench provokes both by cutting random lines short, so that the next strobe arrives before the counter reaches the line length. It drives fresh settings in the strobe cycle itself. The expected values assume that the restart wins and that the new settings govern the whole new line, including the first cycle's H1 mask level. Mid-line scrambling of every setting is judged against the captured copy the bench keeps.

// File: rtl/hblk_pkg.sv
package hblk_pkg;

  typedef struct packed {
    logic ext_sel;
    logic ext_pol;
    logic mask_lvl;
  } hblk_cfg_t;

  function automatic logic pos_usable(input logic [31:0] pos, input logic [31:0] len);
    return (pos != 32'd0) && (pos <= len);
  endfunction

endpackage

// File: rtl/hblk_shadow.sv
module hblk_shadow
  import hblk_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int NUM_TOG = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [CNT_W-1:0]         len_in,
  input  logic [NUM_TOG*CNT_W-1:0] pos_in,
  input  hblk_cfg_t                cfg_in,
  output logic [CNT_W-1:0]         len_q,
  output logic [NUM_TOG*CNT_W-1:0] pos_q,
  output hblk_cfg_t                cfg_q,
  output hblk_cfg_t                cfg_eff
);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      pos_q <= '0;
      cfg_q <= '0;
    end else if (load) begin
      len_q <= len_in;
      pos_q <= pos_in;
      cfg_q <= cfg_in;
    end
  end

  // the line-start cycle already works with the incoming settings
  assign cfg_eff = load ? cfg_in : cfg_q;

endmodule

// File: rtl/hblk_line_counter.sv
module hblk_line_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic [CNT_W-1:0] len_q,
  output logic [CNT_W-1:0] cnt,
  output logic             active
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (line_start) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == len_q) begin
        active <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/hblk_toggle_unit.sv
module hblk_toggle_unit
  import hblk_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int NUM_TOG = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     line_start,
  input  logic                     active,
  input  logic [CNT_W-1:0]         cnt,
  input  logic [CNT_W-1:0]         len_q,
  input  logic [NUM_TOG*CNT_W-1:0] pos_q,
  output logic                     state_next
);

  logic [NUM_TOG-1:0] hit;
  logic               state_q;
  logic               flip;

  for (genvar i = 0; i < NUM_TOG; i++) begin : g_cmp
    logic [CNT_W-1:0] pos_i;
    assign pos_i  = pos_q[i*CNT_W +: CNT_W];
    assign hit[i] = active
                    && pos_usable(32'(pos_i), 32'(len_q))
                    && (pos_i == cnt);
  end

  assign flip       = ^hit;
  assign state_next = line_start ? 1'b0 : (state_q ^ flip);

  always_ff @(posedge clk) begin
    if (rst) state_q <= 1'b0;
    else     state_q <= state_next;
  end

endmodule

// File: rtl/hblk_ext_sync.sv
module hblk_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/hblk_gen.sv
module hblk_gen
  import hblk_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int NUM_TOG = 6,
  parameter int SYNC_N  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     line_start,
  input  logic [CNT_W-1:0]         line_len,
  input  logic [NUM_TOG*CNT_W-1:0] tog_pos,
  input  logic                     cfg_ext_sel,
  input  logic                     cfg_ext_pol,
  input  logic                     cfg_mask_lvl,
  input  logic                     ext_hblk,
  input  logic                     h1_in,
  output logic                     hblk_out,
  output logic                     h1_out
);

  hblk_cfg_t              cfg_in, cfg_q, cfg_eff;
  logic [CNT_W-1:0]         len_q, cnt;
  logic [NUM_TOG*CNT_W-1:0] pos_q;
  logic                     active, int_next, sync_s, ext_norm;
  logic                     blank_d, h1_d;

  assign cfg_in = '{ext_sel: cfg_ext_sel, ext_pol: cfg_ext_pol, mask_lvl: cfg_mask_lvl};

  hblk_shadow #(.CNT_W(CNT_W), .NUM_TOG(NUM_TOG)) u_shadow (
    .clk(clk), .rst(rst), .load(line_start),
    .len_in(line_len), .pos_in(tog_pos), .cfg_in(cfg_in),
    .len_q(len_q), .pos_q(pos_q), .cfg_q(cfg_q), .cfg_eff(cfg_eff)
  );

  hblk_line_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .line_start(line_start),
    .len_q(len_q), .cnt(cnt), .active(active)
  );

  hblk_toggle_unit #(.CNT_W(CNT_W), .NUM_TOG(NUM_TOG)) u_toggle (
    .clk(clk), .rst(rst), .line_start(line_start), .active(active),
    .cnt(cnt), .len_q(len_q), .pos_q(pos_q), .state_next(int_next)
  );

  hblk_ext_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(ext_hblk), .q(sync_s)
  );

  assign ext_norm = ~(sync_s ^ cfg_eff.ext_pol);
  assign blank_d  = cfg_eff.ext_sel ? ext_norm : int_next;
  assign h1_d     = blank_d ? cfg_eff.mask_lvl : h1_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      hblk_out <= 1'b0;
      h1_out   <= 1'b0;
    end else begin
      hblk_out <= blank_d;
      h1_out   <= h1_d;
    end
  end

endmodule

// File: rtl/hblk_gen_chk.sv
module hblk_gen_chk (
  input logic clk,
  input logic rst,
  input logic line_start,
  input logic cfg_ext_sel,
  input logic h1_in,
  input logic hblk_out,
  input logic h1_out,
  input logic active,
  input logic ext_q,
  input logic pol_q,
  input logic mask_q,
  input logic sync_s
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!hblk_out && !h1_out));

  p_start_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (line_start && !cfg_ext_sel) |=> !hblk_out);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!line_start && !active && !ext_q) |=> $stable(hblk_out));

  p_ext_follow_r6: assert property (@(posedge clk) disable iff (rst)
    (ext_q && !line_start) |=> (hblk_out == ~($past(sync_s) ^ pol_q)));

  p_mask_level_r8: assert property (@(posedge clk) disable iff (rst)
    hblk_out |-> (h1_out == mask_q));

  p_h1_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !hblk_out) |-> (h1_out == $past(h1_in)));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> ($stable(ext_q) && $stable(pol_q) && $stable(mask_q)));

endmodule

bind hblk_gen hblk_gen_chk u_chk (
  .clk(clk), .rst(rst), .line_start(line_start), .cfg_ext_sel(cfg_ext_sel),
  .h1_in(h1_in), .hblk_out(hblk_out), .h1_out(h1_out), .active(active),
  .ext_q(cfg_q.ext_sel), .pol_q(cfg_q.ext_pol), .mask_q(cfg_q.mask_lvl),
  .sync_s(sync_s)
);

// File: tb/test_hblk_gen.sv
module test_hblk_gen;
  localparam int W = 12;
  localparam int N = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst, line_start, cfg_ext_sel, cfg_ext_pol, cfg_mask_lvl;
  logic           ext_hblk, h1_in, hblk_out, h1_out;
  logic [W-1:0]   line_len;
  logic [N*W-1:0] tog_pos;

  hblk_gen #(.CNT_W(W), .NUM_TOG(N)) i_hblk_gen (
    .clk(clk), .rst(rst), .line_start(line_start), .line_len(line_len),
    .tog_pos(tog_pos), .cfg_ext_sel(cfg_ext_sel), .cfg_ext_pol(cfg_ext_pol),
    .cfg_mask_lvl(cfg_mask_lvl), .ext_hblk(ext_hblk), .h1_in(h1_in),
    .hblk_out(hblk_out), .h1_out(h1_out)
  );

  int checks = 0;
  int errors = 0;
  int age    = 100;
  logic h1_prev = 1'b0;

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_int(int len, int p[N], int j);
    logic par = 1'b0;
    for (int i = 0; i < N; i++)
      if (p[i] != 0 && p[i] <= len && j >= p[i] + 1) par = ~par;
    return par;
  endfunction

  function automatic logic [N*W-1:0] pack(int p[N]);
    logic [N*W-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(p[i]);
    return v;
  endfunction

  task automatic drive_h1();
    h1_in   = 1'($urandom);
    h1_prev = h1_in;
  endtask

  task automatic run_line(int len, int p[N], bit ext, bit pol, bit msk,
                          int run_len, bit disturb, string tag);
    logic e;
    string t;
    @(negedge clk);
    age++;
    line_start   = 1'b1;
    line_len     = W'(len);
    tog_pos      = pack(p);
    cfg_ext_sel  = ext;
    cfg_ext_pol  = pol;
    cfg_mask_lvl = msk;
    drive_h1();
    for (int j = 0; j < run_len; j++) begin
      @(negedge clk);
      age++;
      line_start = 1'b0;
      if (ext) begin
        if (age >= 3) begin
          e = pol ? ext_hblk : ~ext_hblk;
          t = disturb ? "R9" : (pol ? "R6" : "R7");
          check(t, hblk_out, e);
          check("R8", h1_out, e ? msk : h1_prev);
        end
      end else begin
        e = exp_int(len, p, j);
        t = (j > len) ? "R5" : tag;
        if (disturb && j > run_len / 2) t = "R9";
        check(t, hblk_out, e);
        check("R8", h1_out, e ? msk : h1_prev);
      end
      drive_h1();
      if ($urandom % 5 == 0) begin
        ext_hblk = ~ext_hblk;
        age      = 0;
      end
      if (disturb && j == run_len / 2) begin
        line_len     = W'($urandom);
        tog_pos      = {N{W'($urandom_range(0, 40))}};
        cfg_ext_sel  = 1'($urandom);
        cfg_ext_pol  = 1'($urandom);
        cfg_mask_lvl = 1'($urandom);
      end
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int p[N];
    int len, rl;
    void'($urandom(32'd4242));
    rst = 1'b1; line_start = 1'b0; line_len = W'(20);
    tog_pos = pack('{1, 2, 3, 4, 5, 6});
    cfg_ext_sel = 1'b0; cfg_ext_pol = 1'b1; cfg_mask_lvl = 1'b1;
    ext_hblk = 1'b0; h1_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", hblk_out, 1'b0);
    check("R1", h1_out, 1'b0);
    rst = 1'b0;
    // R1: no line start yet, programmed positions must not blank
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check("R1", hblk_out, 1'b0);
      h1_in = 1'($urandom);
    end

    // R2 standard interval
    p = '{5, 15, 0, 0, 0, 0};
    run_line(30, p, 0, 0, 0, 34, 0, "R2");
    // R2 six positions, extra pulse groups
    p = '{3, 20, 6, 8, 11, 14};
    run_line(25, p, 0, 1, 1, 29, 0, "R2");
    // R3 zero and beyond-length positions, one at exactly the line length
    p = '{0, 40, 12, 2, 31, 0};
    run_line(12, p, 0, 1, 1, 18, 0, "R3");
    // R4 duplicates cancel
    p = '{7, 7, 9, 9, 9, 4};
    run_line(15, p, 0, 0, 1, 20, 0, "R4");
    // R9 mid-line scramble, internal
    p = '{4, 10, 0, 0, 0, 0};
    run_line(16, p, 0, 1, 1, 22, 1, "R9");
    // R6 / R7 external modes, including mid-line scramble
    run_line(20, p, 1, 1, 0, 30, 0, "R6");
    run_line(20, p, 1, 0, 1, 30, 0, "R7");
    run_line(20, p, 1, 0, 0, 30, 1, "R9");

    // random lines, some cut short so the next start collides with toggles
    for (int n = 0; n < 80; n++) begin
      len = $urandom_range(4, 60);
      for (int i = 0; i < N; i++) p[i] = $urandom_range(0, len + 8);
      if ($urandom % 4 == 0) p[1] = p[0];
      rl = ($urandom % 3 == 0) ? $urandom_range(1, len) : len + 4;
      run_line(len, p, ($urandom % 4) == 0, 1'($urandom), 1'($urandom),
               rl, ($urandom % 5) == 0, "R2");
    end
    finish_run();
  end

endmodule